// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block sits beside a small CPU core and decides, at each instruction boundary, which pending event the core services next and from which vector address the core fetches the handler. Six request sources feed it: the reset request, the non-maskable request, the external maskable request and three timer events (input capture, output compare, counter overflow). Each request is latched as a level-held pending bit. The bit stays set until that source is serviced or the block is reset. The core supplies its interrupt-mask flag, three per-source timer enable bits, its wait-state flag, a boundary strobe and a software-interrupt strobe.

When the boundary strobe is high, only the highest-priority pending source is examined. If its gating conditions hold, the block issues a one-cycle grant carrying the vector, a source code, a one-hot clear strobe for the serviced pending bit and, when the core was waiting, a wait-clear strobe. If that source is gated off, nothing is granted and nothing lower is tried until the next boundary. The software-interrupt strobe is granted unconditionally through its own vector. The block also reports whether a waiting core must stay idle, which it must while no request is pending.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Priority, highest first, is pending bit 0 (reset), 1 (NMI), 2 (IRQ), 3 (input capture), 4 (output compare), 5 (overflow). A boundary examines only the highest pending bit. If that source is gated off, no grant is made and no lower source is granted at that boundary.
- R2: A grant carries the vector 0xFFFE for reset, 0xFFFC for NMI, 0xFFF8 for IRQ, 0xFFF6 for input capture, 0xFFF4 for output compare, 0xFFF2 for overflow and 0xFFFA for software interrupt. It also carries the source code 1 to 6 in the same order as the pending bits, and 7 for the software interrupt.
- R3: NMI and reset are granted whatever the mask flag is. IRQ is granted only when the mask flag is 0.
- R4: A timer source is granted only when the mask flag is 0 and its own enable bit is 1. Bit 0 of `tmr_en` enables input capture, bit 1 output compare and bit 2 overflow.
- R5: A `swi_i` pulse gives a grant with vector 0xFFFA and source 7 in the next cycle, whatever the mask flag is, and leaves the pending bits unchanged. It takes precedence over a simultaneous boundary, unless reset is the highest pending source.
- R6: A granted reset raises `reset_act` for one cycle and clears every pending bit. A low `rst_n` clears all pending bits and all outputs.
- R7: `cpu_idle` is 1 exactly when `wait_st` is 1 and no pending bit is set.
- R8: A hardware grant drives `pend_clr` one-hot at the serviced bit and clears that pending bit. `wait_clr` accompanies any grant made while `wait_st` was 1.
- R9: A `req_set` bit sampled at a clock edge becomes pending at that edge. A boundary decision uses the pending bits present before its edge, and the grant outputs appear one cycle after the boundary strobe. An ungranted pending bit is kept for later boundaries.
- R10: Out of reset, `take`, `vector`, `src_id`, `pend_clr`, `reset_act` and `wait_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 6 | Request inputs, bit 0 reset through bit 5 overflow |
| mask_i | input | 1 | CPU interrupt-mask flag |
| tmr_en | input | 3 | Timer enables: input capture, output compare, overflow |
| wait_st | input | 1 | CPU is in the wait state |
| chk_i | input | 1 | Instruction-boundary check strobe |
| swi_i | input | 1 | Software-interrupt strobe |
| take | output | 1 | Grant pulse |
| vector | output | 16 | Vector address of the grant |
| src_id | output | 3 | Source code of the grant |
| reset_act | output | 1 | Reset-action pulse |
| pend_clr | output | 6 | One-hot clear of the serviced pending bit |
| wait_clr | output | 1 | Wait-flag clear strobe |
| cpu_idle | output | 1 | Waiting core must stay idle |

## Verification
A corrupted pending register shows up in two ways. `cpu_idle` would disagree with the requests already delivered, in the cycle right after they were delivered. A later boundary would grant the wrong source, or a source that was never requested, one cycle after its strobe. A faulty priority chain or faulty gate logic shows up at the first boundary, as a wrong or missing grant, vector or clear strobe. A missing clear shows up at the following boundary as a repeated grant. The sweep covers every pending pattern under every combination of mask and enable settings, and it always follows a first decision with a second, fully unmasked one, so that state left behind by the first decision becomes visible.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int NFIX = 3;              // reset, NMI, IRQ
  localparam int NTMR = 3;              // capture, compare, overflow
  localparam int NSRC = NFIX + NTMR;
  localparam int VW   = 16;
  localparam int IDW  = 3;
  localparam logic [VW-1:0] VEC_TOP = 16'hFFFE;
  localparam logic [VW-1:0] VEC_SWI = VEC_TOP - 16'd4;

  typedef enum logic [IDW-1:0] {
    SRC_NONE = 3'd0, SRC_RST = 3'd1, SRC_NMI = 3'd2, SRC_IRQ = 3'd3,
    SRC_ICAP = 3'd4, SRC_OCMP = 3'd5, SRC_TOVF = 3'd6, SRC_SWI = 3'd7
  } src_e;

  typedef struct packed {
    logic            take;
    logic [VW-1:0]   vec;
    logic [IDW-1:0]  src;
    logic [NSRC-1:0] clr;
    logic            rst_act;
    logic            wait_clr;
  } decision_t;

  // Vector slots step down by two; slot of the software interrupt is skipped.
  function automatic logic [VW-1:0] vec_of_level(input int lvl);
    if (lvl < 2) return VEC_TOP - VW'(2 * lvl);
    return VEC_TOP - VW'(2 * (lvl + 1));
  endfunction

  // Level 0,1 unmaskable; level 2 needs mask clear; timer levels need enable too.
  function automatic logic gate_open(input int lvl, input logic mask,
                                     input logic [NTMR-1:0] en);
    logic ok;
    ok = 1'b0;
    if (lvl < NFIX - 1) ok = 1'b1;
    else if (lvl == NFIX - 1) ok = ~mask;
    else begin
      for (int k = 0; k < NTMR; k++)
        if (lvl == NFIX + k) ok = ~mask & en[k];
    end
    return ok;
  endfunction

  function automatic int onehot_idx(input logic [NSRC-1:0] v);
    int idx;
    idx = 0;
    for (int k = 0; k < NSRC; k++)
      if (v[k]) idx = k;
    return idx;
  endfunction
endpackage

// File: rtl/irqarb_pending.sv
module irqarb_pending
  import irqarb_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         clr_all_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] keep_mask;
  assign keep_mask = clr_all_i ? '0 : ~clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & keep_mask) | set_i;
  end
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic            [N-1:0] pend_i,
  input  logic                    mask_i,
  input  logic [NTMR-1:0]         en_i,
  output logic            [N-1:0] grant_o
);
  logic [N:0]   seen;
  logic [N-1:0] first;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign first[g]    = pend_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | pend_i[g];
    assign grant_o[g]  = first[g] & gate_open(g, mask_i, en_i);
  end
endmodule

// File: rtl/irqarb_outreg.sv
module irqarb_outreg
  import irqarb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  decision_t nxt_i,
  output decision_t cur_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur_o <= '0;
    else        cur_o <= nxt_i;
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_set,
  input  logic             mask_i,
  input  logic [NTMR-1:0]  tmr_en,
  input  logic             wait_st,
  input  logic             chk_i,
  input  logic             swi_i,
  output logic             take,
  output logic [VW-1:0]    vector,
  output logic [IDW-1:0]   src_id,
  output logic             reset_act,
  output logic [NSRC-1:0]  pend_clr,
  output logic             wait_clr,
  output logic             cpu_idle
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] clr_now;
  logic            hw_take;
  logic            rst_take;
  logic            swi_take;
  int              lvl;
  decision_t       nxt;
  decision_t       cur;

  irqarb_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(clr_now),
    .clr_all_i(rst_take), .pend_o(pend_q)
  );

  irqarb_select #(.N(NSRC)) u_sel (
    .pend_i(pend_q), .mask_i(mask_i), .en_i(tmr_en), .grant_o(grant)
  );

  assign rst_take = chk_i & grant[0];
  assign hw_take  = chk_i & (|grant) & (rst_take | ~swi_i);
  assign swi_take = swi_i & ~rst_take;
  assign clr_now  = hw_take ? grant : '0;
  assign lvl      = onehot_idx(grant);

  always_comb begin
    nxt = '0;
    if (hw_take) begin
      nxt.take     = 1'b1;
      nxt.vec      = vec_of_level(lvl);
      nxt.src      = IDW'(lvl + 1);
      nxt.clr      = grant;
      nxt.rst_act  = grant[0];
      nxt.wait_clr = wait_st;
    end else if (swi_take) begin
      nxt.take     = 1'b1;
      nxt.vec      = VEC_SWI;
      nxt.src      = SRC_SWI;
      nxt.wait_clr = wait_st;
    end
  end

  irqarb_outreg u_out (.clk(clk), .rst_n(rst_n), .nxt_i(nxt), .cur_o(cur));

  assign take      = cur.take;
  assign vector    = cur.vec;
  assign src_id    = cur.src;
  assign reset_act = cur.rst_act;
  assign pend_clr  = cur.clr;
  assign wait_clr  = cur.wait_clr;
  assign cpu_idle  = wait_st & ~(|pend_q);
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk
  import irqarb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_set,
  input logic            mask_i,
  input logic [NTMR-1:0] tmr_en,
  input logic            chk_i,
  input logic            swi_i,
  input logic            take,
  input logic [VW-1:0]   vector,
  input logic [IDW-1:0]  src_id,
  input logic            reset_act,
  input logic [NSRC-1:0] pend_clr,
  input logic            wait_clr,
  input logic [NSRC-1:0] pend_q
);
  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));
  p_wait_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_clr |-> take);
  p_nmi_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_NMI) |-> vector == 16'hFFFC);
  p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_IRQ) |-> !$past(mask_i));
  p_icap_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_ICAP) |-> (!$past(mask_i) && $past(tmr_en[0])));
  p_ocmp_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_OCMP) |-> (!$past(mask_i) && $past(tmr_en[1])));
  p_tovf_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_TOVF) |-> (!$past(mask_i) && $past(tmr_en[2])));
  p_swi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_i && !chk_i) |=> (take && src_id == SRC_SWI && vector == 16'hFFFA));
  p_reset_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_act |-> (take && vector == 16'hFFFE && src_id == SRC_RST));
  p_nmi_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src_id == SRC_NMI) |-> (!pend_q[1] || $past(req_set[1])));
endmodule

bind irq_vector_arbiter irqarb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_set(req_set), .mask_i(mask_i),
  .tmr_en(tmr_en), .chk_i(chk_i), .swi_i(swi_i), .take(take),
  .vector(vector), .src_id(src_id), .reset_act(reset_act),
  .pend_clr(pend_clr), .wait_clr(wait_clr), .pend_q(pend_q)
);

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req_set = '0;
  logic        mask_i = 1'b0;
  logic [2:0]  tmr_en = '0;
  logic        wait_st = 1'b0;
  logic        chk_i = 1'b0;
  logic        swi_i = 1'b0;
  logic        take;
  logic [15:0] vector;
  logic [2:0]  src_id;
  logic        reset_act;
  logic [5:0]  pend_clr;
  logic        wait_clr;
  logic        cpu_idle;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .mask_i(mask_i),
    .tmr_en(tmr_en), .wait_st(wait_st), .chk_i(chk_i), .swi_i(swi_i),
    .take(take), .vector(vector), .src_id(src_id), .reset_act(reset_act),
    .pend_clr(pend_clr), .wait_clr(wait_clr), .cpu_idle(cpu_idle)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int i);
    case (i)
      0: return 16'hFFFE;
      1: return 16'hFFFC;
      2: return 16'hFFF8;
      3: return 16'hFFF6;
      4: return 16'hFFF4;
      default: return 16'hFFF2;
    endcase
  endfunction

  function automatic int first_bit(input logic [5:0] p);
    for (int i = 0; i < 6; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic bit allowed(input int i, input logic m, input logic [2:0] e);
    if (i <= 1) return 1'b1;
    if (i == 2) return !m;
    return !m && e[i-3];
  endfunction

  // {take, vector, src, clr, reset_act, wait_clr}
  function automatic logic [27:0] expect_out(input logic [5:0] p, input logic m,
                                             input logic [2:0] e, input logic w);
    int i;
    i = first_bit(p);
    if (i < 0 || !allowed(i, m, e)) return '0;
    return {1'b1, exp_vec(i), 3'(i + 1), 6'(1 << i), (i == 0), w};
  endfunction

  function automatic logic [27:0] got();
    return {take, vector, src_id, pend_clr, reset_act, wait_clr};
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R6";
      1: return "R3";
      2: return "R3";
      3, 4, 5: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_set = '0; chk_i = 0; swi_i = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [27:0] e1;
    logic [5:0]  rem;
    int          i1;

    // R10: reset state
    do_reset();
    check(got() == '0, "R10 reset outputs", 32'(got()), 32'h0);

    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 64; p++) begin
        do_reset();
        wait_st = 1'b1;
        req_set = 6'(p);
        @(negedge clk);
        req_set = '0;
        // R7 / R9: pending set by last edge
        check(cpu_idle == (p == 0), "R7 idle vs pending", 32'(cpu_idle), 32'(p == 0));
        mask_i = m[3]; tmr_en = m[2:0]; chk_i = 1'b1;
        @(negedge clk);
        i1 = first_bit(6'(p));
        e1 = expect_out(6'(p), m[3], m[2:0], 1'b1);
        check(got() == e1, (e1[27] || i1 < 0) ? tag_of(i1) : "R1 blocked", 32'(got()), 32'(e1));
        if (e1[27]) begin
          check(vector == exp_vec(i1), "R2 vector", 32'(vector), 32'(exp_vec(i1)));
          check(pend_clr == 6'(1 << i1) && wait_clr, "R8 clear strobes",
                32'({pend_clr, wait_clr}), 32'({6'(1 << i1), 1'b1}));
        end
        rem = e1[27] ? ((i1 == 0) ? 6'd0 : (6'(p) & ~6'(1 << i1))) : 6'(p);
        wait_st = 1'b0; mask_i = 1'b0; tmr_en = 3'b111;
        @(negedge clk);
        e1 = expect_out(rem, 1'b0, 3'b111, 1'b0);
        check(got() == e1, "R9 second boundary", 32'(got()), 32'(e1));
        chk_i = 1'b0;
      end
    end

    // R5: software interrupt, masked, pending untouched
    for (int p = 0; p < 64; p += 7) begin
      do_reset();
      req_set = 6'(p) & 6'b111110;
      @(negedge clk);
      req_set = '0; mask_i = 1'b1; tmr_en = '0; swi_i = 1'b1;
      @(negedge clk);
      swi_i = 1'b0;
      check(got() == {1'b1, 16'hFFFA, 3'd7, 6'd0, 1'b0, 1'b0}, "R5 swi grant",
            32'(got()), 32'({1'b1, 16'hFFFA, 3'd7, 6'd0, 1'b0, 1'b0}));
      mask_i = 1'b0; tmr_en = 3'b111; chk_i = 1'b1;
      @(negedge clk);
      chk_i = 1'b0;
      e1 = expect_out(6'(p) & 6'b111110, 1'b0, 3'b111, 1'b0);
      check(got() == e1, "R5 pending kept after swi", 32'(got()), 32'(e1));
    end

    // R5 / R6: reset pending beats simultaneous swi
    do_reset();
    req_set = 6'b000011;
    @(negedge clk);
    req_set = '0; swi_i = 1'b1; chk_i = 1'b1;
    @(negedge clk);
    swi_i = 1'b0;
    check(reset_act && vector == 16'hFFFE, "R6 reset over swi",
          32'({reset_act, vector}), 32'({1'b1, 16'hFFFE}));
    @(negedge clk);
    chk_i = 1'b0;
    check(take == 1'b0, "R6 all pending dropped", 32'(take), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule